// File: doc/BRIEF.md
# Power-State Change Notifier

This block holds a small power-management control word on the host side. Configuration writes from the host update a two-bit power-state field in that word. Whenever a write gives the field a new value, the block sends a single active-low notice into a separate local clock domain, one local clock wide. A local agent that keeps track of earlier states has to latch the current state when the notice arrives, because the block stores only the present state.

The block also carries wake requests from the local side to the host. A rising edge on the local wake-request line sets a sticky event flag in the control word and pulls an active-low wake line toward the host. Software writes a 1 to the flag to clear it, and that releases the wake line.

The host write port has no valid/ready handshake. It is a plain register port, and a write is taken on every host clock edge where the write strobe is high, so it never applies back-pressure. The power-state field stays in the host domain. Only a change toggle crosses to the local side, and only a wake level crosses to the host side, each through a two-flop synchronizer.

Top module: `pmn_notifier`

## Requirements
- R1: On reset the power state is 00, the event flag is 0, `wake_n` is high and `state_pulse_n` is high.
- R2: A host write stores `wr_data[1:0]` as the power state. From the next host cycle, `rd_word[1:0]` shows that state and every other bit of `rd_word` except bit 15 reads 0.
- R3: A write that changes the power state produces exactly one low cycle on `state_pulse_n`, one local clock wide. It appears within five local clocks of the write.
- R4: `state_pulse_n` is high except during these notices. Each notice lasts exactly one local clock.
- R5: A write that stores the power state it already holds produces no notice.
- R6: Two state changes at least four local clocks apart each produce their own notice.
- R7: A rising edge on `wake_req` passes through two host-clock flops. It then sets the event flag, `rd_word[15]`, and drives `wake_n` low within four host clocks.
- R8: The flag is set only by an edge of `wake_req`. If `wake_req` stays high after the flag is cleared, the flag is not set again.
- R9: A write with `wr_data[15]=1` clears the flag and raises `wake_n` on the next host cycle. A write with `wr_data[15]=0` leaves the flag unchanged.
- R10: If a wake edge and a clearing write reach the flag in the same host cycle, the set wins and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data: bits 1:0 are the power state, bit 15 is write-1-to-clear for the flag |
| rd_word | output | 16 | Current control word: bits 1:0 are the state, bit 15 is the event flag |
| wake_n | output | 1 | Active-low wake line toward the host |
| lclk | input | 1 | Local clock |
| lrst_n | input | 1 | Local-domain reset, active low |
| wake_req | input | 1 | Wake request from the local side, acted on at its rising edge |
| state_pulse_n | output | 1 | Active-low power-state change notice, one local clock wide |

## Verification
The state field and a clearing write are visible one host cycle after the write edge, so the bench reads them on the next falling host edge. A wake edge needs two synchronizer flops plus the flag register. The bench therefore waits six host cycles before it checks the flag. For the set-versus-clear case it places the clearing write on exactly the third host edge after `wake_req` rises. A notice arrives three to four local clocks after the write, so the bench waits ten host cycles before it compares its count of notices with the expected count. A monitor samples each notice on the falling local edge to check its width.

// File: rtl/pmn_pkg.sv
package pmn_pkg;
  localparam int PMN_WORD_W   = 16;
  localparam int PMN_STATE_W  = 2;
  localparam int PMN_FLAG_BIT = 15;
  localparam int PMN_SYNC_N   = 2;
endpackage

// File: rtl/pmn_sync.sv
module pmn_sync #(
  parameter int W      = 1,
  parameter int STAGES = pmn_pkg::PMN_SYNC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= '0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pmn_host_regs.sv
module pmn_host_regs #(
  parameter int WORD_W   = pmn_pkg::PMN_WORD_W,
  parameter int STATE_W  = pmn_pkg::PMN_STATE_W,
  parameter int FLAG_BIT = pmn_pkg::PMN_FLAG_BIT,
  parameter int SYNC_N   = pmn_pkg::PMN_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wake_async,
  output logic [WORD_W-1:0] word,
  output logic              chg_tgl,
  output logic              wake_n
);
  logic [STATE_W-1:0] state_q;
  logic               flag_q;
  logic               tgl_q;
  logic               wake_s;
  logic               wake_prev;
  logic               wake_rise;
  logic               clr_req;
  logic               changed;

  pmn_sync #(.W(1), .STAGES(SYNC_N)) u_wake_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (wake_async),
    .q    (wake_s)
  );

  assign wake_rise = wake_s & ~wake_prev;
  assign clr_req   = wr_en & wr_data[FLAG_BIT];
  assign changed   = wr_en & (wr_data[STATE_W-1:0] != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= '0;
      flag_q    <= 1'b0;
      tgl_q     <= 1'b0;
      wake_prev <= 1'b0;
    end else begin
      wake_prev <= wake_s;
      if (wr_en) state_q <= wr_data[STATE_W-1:0];
      if (changed) tgl_q <= ~tgl_q;
      // the set takes priority over a clear in the same cycle
      flag_q <= wake_rise | (flag_q & ~clr_req);
    end
  end

  always_comb begin
    word                = '0;
    word[STATE_W-1:0]   = state_q;
    word[FLAG_BIT]      = flag_q;
  end

  assign chg_tgl = tgl_q;
  assign wake_n  = ~flag_q;

  p_state_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (word[STATE_W-1:0] == $past(wr_data[STATE_W-1:0])));

  p_change_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[STATE_W-1:0] != word[STATE_W-1:0])) |=> (chg_tgl != $past(chg_tgl)));

  p_same_no_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (wr_data[STATE_W-1:0] == word[STATE_W-1:0])) |=> $stable(chg_tgl));

  p_rise_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rise |=> !wake_n);

  p_clear_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !wake_rise) |=> wake_n);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_rise && !clr_req) |=> $stable(wake_n));
endmodule

// File: rtl/pmn_local_pulse.sv
module pmn_local_pulse #(
  parameter int SYNC_N = pmn_pkg::PMN_SYNC_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_async,
  output logic pulse_n
);
  logic tgl_s;
  logic tgl_prev;
  logic pulse_nq;

  pmn_sync #(.W(1), .STAGES(SYNC_N)) u_tgl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (tgl_async),
    .q    (tgl_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_prev <= 1'b0;
      pulse_nq <= 1'b1;
    end else begin
      tgl_prev <= tgl_s;
      pulse_nq <= ~(tgl_s ^ tgl_prev);
    end
  end

  assign pulse_n = pulse_nq;

  p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_n |=> pulse_n);

  p_edge_makes_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_s != tgl_prev) |=> !pulse_n);
endmodule

// File: rtl/pmn_notifier.sv
module pmn_notifier #(
  parameter int WORD_W   = pmn_pkg::PMN_WORD_W,
  parameter int STATE_W  = pmn_pkg::PMN_STATE_W,
  parameter int FLAG_BIT = pmn_pkg::PMN_FLAG_BIT,
  parameter int SYNC_N   = pmn_pkg::PMN_SYNC_N
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_word,
  output logic              wake_n,
  input  logic              lclk,
  input  logic              lrst_n,
  input  logic              wake_req,
  output logic              state_pulse_n
);
  logic chg_tgl;

  pmn_host_regs #(
    .WORD_W(WORD_W), .STATE_W(STATE_W), .FLAG_BIT(FLAG_BIT), .SYNC_N(SYNC_N)
  ) u_host (
    .clk       (hclk),
    .rst_n     (hrst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wake_async(wake_req),
    .word      (rd_word),
    .chg_tgl   (chg_tgl),
    .wake_n    (wake_n)
  );

  pmn_local_pulse #(.SYNC_N(SYNC_N)) u_local (
    .clk      (lclk),
    .rst_n    (lrst_n),
    .tgl_async(chg_tgl),
    .pulse_n  (state_pulse_n)
  );
endmodule

// File: tb/tb_pmn_notifier.sv
module tb_pmn_notifier;
  logic        hclk = 1'b0;
  logic        lclk = 1'b0;
  logic        hrst_n = 1'b0;
  logic        lrst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_word;
  logic        wake_n;
  logic        wake_req = 1'b0;
  logic        state_pulse_n;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int wide = 0;
  int exp_pulses = 0;
  logic [1:0] exp_state = 2'b00;
  logic prev_low = 1'b0;
  logic done = 1'b0;

  always #5 hclk = ~hclk;
  always #7 lclk = ~lclk;

  pmn_notifier dut (
    .hclk(hclk), .hrst_n(hrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_word(rd_word), .wake_n(wake_n), .lclk(lclk), .lrst_n(lrst_n),
    .wake_req(wake_req), .state_pulse_n(state_pulse_n)
  );

  always @(negedge lclk) begin
    if (lrst_n) begin
      if (!state_pulse_n) begin
        pulses++;
        if (prev_low) wide++;
      end
      prev_low <= !state_pulse_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hwait(input int n);
    for (int i = 0; i < n; i++) @(negedge hclk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge hclk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge hclk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  function automatic int pulses_for(input logic [1:0] old_s, input logic [1:0] new_s);
    return (old_s != new_s) ? 1 : 0;
  endfunction

  task automatic state_step(input logic [1:0] s, input string tag);
    exp_pulses += pulses_for(exp_state, s);
    exp_state = s;
    wr({14'd0, s});
    chk(rd_word == {14'd0, s}, tag, rd_word, {14'd0, s});
    hwait(10);
    chk(pulses == exp_pulses, tag, pulses, exp_pulses);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e));
    hwait(3);
    hrst_n = 1'b1;
    lrst_n = 1'b1;
    hwait(2);
    // R1 reset state
    chk(rd_word == 16'h0000, "R1 word", rd_word, 0);
    chk(wake_n == 1'b1, "R1 wake_n", wake_n, 1);
    chk(state_pulse_n == 1'b1, "R1 pulse_n", state_pulse_n, 1);

    // R2 R3 directed changes; upper data bits are ignored in the state field
    state_step(2'b10, "R3 first change");
    exp_pulses += 1;
    exp_state = 2'b01;
    wr(16'h7ffd);
    chk(rd_word == 16'h0001, "R2 other bits read 0", rd_word, 1);
    hwait(10);
    chk(pulses == exp_pulses, "R3 change with noisy bits", pulses, exp_pulses);

    // R5 same value writes
    state_step(2'b01, "R5 same state");
    state_step(2'b01, "R5 same state again");

    // R6 two changes six host cycles apart (60 ns, more than four local clocks)
    wr(16'h0003);
    hwait(4);
    wr(16'h0000);
    exp_pulses += 2;
    exp_state = 2'b00;
    hwait(10);
    chk(pulses == exp_pulses, "R6 close changes", pulses, exp_pulses);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [1:0] s;
      s = 2'($urandom % 4);
      state_step(s, "R3 R5 random");
    end
    chk(wide == 0, "R4 pulse width", wide, 0);

    // R7 wake edge sets flag
    @(negedge hclk);
    wake_req = 1'b1;
    hwait(6);
    chk(rd_word[15] == 1'b1, "R7 flag set", rd_word[15], 1);
    chk(wake_n == 1'b0, "R7 wake_n low", wake_n, 0);

    // R9 write with bit15=0 keeps the flag
    wr({14'd0, exp_state});
    chk(wake_n == 1'b0, "R9 zero write keeps", wake_n, 0);
    // R9 clear
    wr({1'b1, 13'd0, exp_state});
    chk(rd_word[15] == 1'b0, "R9 flag cleared", rd_word[15], 0);
    chk(wake_n == 1'b1, "R9 wake_n released", wake_n, 1);
    // R8 level held high does not set again
    hwait(8);
    chk(wake_n == 1'b1, "R8 no re-set on level", wake_n, 1);
    @(negedge hclk);
    wake_req = 1'b0;
    hwait(6);

    // R10 set and clear in the same host cycle: the edge reaches the flag on the third host edge
    @(negedge hclk);
    wake_req = 1'b1;
    @(negedge hclk);
    @(negedge hclk);
    wr_en = 1'b1;
    wr_data = {1'b1, 13'd0, exp_state};
    @(negedge hclk);
    wr_en = 1'b0;
    wr_data = '0;
    chk(wake_n == 1'b0, "R10 set wins", wake_n, 0);
    wr({1'b1, 13'd0, exp_state});
    chk(wake_n == 1'b1, "R9 final clear", wake_n, 1);
    wake_req = 1'b0;
    hwait(10);
    chk(pulses == exp_pulses, "R5 no pulse from flag writes", pulses, exp_pulses);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule